// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits between the CPU of a small 8-bit system and its memories. It watches a 16-bit address bus with read and write strobes. For every access it raises exactly one region select and computes the offset of the address inside that region. The result is registered, so selects and offset appear in the clock cycle after the strobe. Downstream memories use the select as their enable and the offset as their local address.

After reset, a small boot ROM covers the lowest 256 addresses in place of the cartridge ROM. A two-state controller tracks this overlay. It starts in `ST_BOOT`, where the overlay is live. The transition *boot exit* moves it to `ST_CART`, and that state is kept until the next reset. *Boot exit* is a write of a nonzero byte to I/O address 0xFF50. After it, code at 0x0100 and the low page read straight from the cartridge.

The decoder also handles three special areas. It folds the echo window onto work RAM. It reports reads from the unusable hole as unmapped, with an all-ones fill byte. It gives the topmost byte its own select for the interrupt-enable register.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the controller is in ST_BOOT. While in ST_BOOT, an access to 0x0000–0x00FF raises sel bit 0 (boot ROM) with offset equal to the address.
- R2: A write strobe to 0xFF50 with nonzero wr_data takes the boot-exit transition to ST_CART. A zero write, or a read, leaves ST_BOOT in place. In ST_CART, 0x0000–0x00FF raises sel bit 1 with offset equal to the address.
- R3: ST_CART persists. Later writes to 0xFF50, zero or nonzero, never restore the boot ROM mapping; only reset does.
- R4: 0x0000–0x3FFF (outside the overlay) raises sel bit 1 with offset = address. 0x4000–0x7FFF raises sel bit 2 with offset = address − 0x4000.
- R5: 0x8000–0x9FFF raises sel bit 3 (video RAM) with offset = address − 0x8000. 0xA000–0xBFFF raises sel bit 4 (cartridge RAM) with offset = address − 0xA000.
- R6: 0xC000–0xCFFF raises sel bit 5 with offset = address − 0xC000. 0xD000–0xDFFF raises sel bit 6 with offset = address − 0xD000.
- R7: 0xE000–0xFDFF is decoded as address − 0x2000. It raises sel bit 5 or 6, with the offset of that mirrored address.
- R8: 0xFE00–0xFE9F raises sel bit 7 (sprite table), offset − 0xFE00. 0xFF00–0xFF7F raises bit 8 (I/O), offset − 0xFF00. 0xFF80–0xFFFE raises bit 9 (high RAM), offset − 0xFF80. 0xFFFF raises bit 10 (interrupt enable), offset 0.
- R9: A read of 0xFEA0–0xFEFF raises no select and returns offset 0. It asserts unmapped and drives fill_data = 0xFF.
- R10: A write to 0xFEA0–0xFEFF is ignored: no select, unmapped low, fill_data 0x00, offset 0.
- R11: Outputs are registered and reflect the access of the previous cycle. A cycle with neither strobe yields all outputs zero in the next cycle. A cycle with both strobes is handled as a write.
- R12: Every access outside the hole raises exactly one sel bit, and sel never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, re-enters ST_BOOT |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, inspected only for the boot-exit write |
| sel | output | 11 | One-hot region select, bit order as in R1–R8 |
| offset | output | 14 | Offset within the selected region |
| unmapped | output | 1 | High after a read of the hole |
| fill_data | output | 8 | 0xFF after a hole read, else 0x00 |

## Verification
The bound checker watches the following rules on every cycle:
- sel holds at most one bit, and any access outside the hole produces exactly one bit.
- Idle cycles produce quiet outputs.
- Hole reads and writes produce the required flag and fill values.
- Echo addresses always land on a work-RAM select.
- The boot-exit transition follows the write-data rule, and ST_CART never leaves.

Offset arithmetic for each region can only be shown by the bench scenarios. The same holds for the full address-by-address mapping and for the overlay being replaced by the cartridge. These scenarios sweep all 65536 addresses in both states, and they also cover the zero-data write, repeated exit writes, and accesses that raise both strobes.

// File: rtl/bod_pkg.sv
package bod_pkg;
    localparam int ADDR_W = 16;
    localparam int NREG   = 11;
    localparam int RID_W  = 4;

    typedef enum logic [RID_W-1:0] {
        RG_BOOT  = 4'd0,
        RG_CROM0 = 4'd1,
        RG_CROMX = 4'd2,
        RG_VRAM  = 4'd3,
        RG_XRAM  = 4'd4,
        RG_WRAM0 = 4'd5,
        RG_WRAMX = 4'd6,
        RG_OAM   = 4'd7,
        RG_IO    = 4'd8,
        RG_HRAM  = 4'd9,
        RG_IE    = 4'd10,
        RG_HOLE  = 4'd11
    } region_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_CART = 1'b1
    } boot_st_e;

    localparam logic [ADDR_W-1:0] BOOT_TOP   = 16'h00FF;
    localparam logic [ADDR_W-1:0] CROMX_BASE = 16'h4000;
    localparam logic [ADDR_W-1:0] VRAM_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] XRAM_BASE  = 16'hA000;
    localparam logic [ADDR_W-1:0] WRAM0_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] WRAMX_BASE = 16'hD000;
    localparam logic [ADDR_W-1:0] ECHO_BASE  = 16'hE000;
    localparam logic [ADDR_W-1:0] ECHO_SHIFT = 16'h2000;
    localparam logic [ADDR_W-1:0] OAM_BASE   = 16'hFE00;
    localparam logic [ADDR_W-1:0] HOLE_BASE  = 16'hFEA0;
    localparam logic [ADDR_W-1:0] IO_BASE    = 16'hFF00;
    localparam logic [ADDR_W-1:0] HRAM_BASE  = 16'hFF80;
    localparam logic [ADDR_W-1:0] IE_ADDR    = 16'hFFFF;
endpackage

// File: rtl/bootmode_ctl.sv
module bootmode_ctl
    import bod_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = 16'hFF50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              boot_on
);
    boot_st_e state, nxt;
    logic     exit_hit;

    assign exit_hit = wr_en && (addr == EXIT_ADDR) && (wr_data != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT: if (exit_hit) nxt = ST_CART;
            ST_CART: nxt = ST_CART;
            default: nxt = ST_BOOT;
        endcase
    end

    always_comb begin
        boot_on = (state == ST_BOOT);
    end
endmodule

// File: rtl/region_map.sv
module region_map
    import bod_pkg::*;
#(
    parameter int OFF_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_on,
    output region_e           region,
    output logic [OFF_W-1:0]  offset
);
    logic [ADDR_W-1:0] wa;

    always_comb begin
        wa = (addr >= ECHO_BASE) ? (addr - ECHO_SHIFT) : addr;
    end

    always_comb begin
        region = RG_HOLE;
        offset = '0;
        if (boot_on && addr <= BOOT_TOP) begin
            region = RG_BOOT;
            offset = OFF_W'(addr);
        end else if (addr < CROMX_BASE) begin
            region = RG_CROM0;
            offset = OFF_W'(addr);
        end else if (addr < VRAM_BASE) begin
            region = RG_CROMX;
            offset = OFF_W'(addr - CROMX_BASE);
        end else if (addr < XRAM_BASE) begin
            region = RG_VRAM;
            offset = OFF_W'(addr - VRAM_BASE);
        end else if (addr < WRAM0_BASE) begin
            region = RG_XRAM;
            offset = OFF_W'(addr - XRAM_BASE);
        end else if (addr < OAM_BASE) begin
            if (wa < WRAMX_BASE) begin
                region = RG_WRAM0;
                offset = OFF_W'(wa - WRAM0_BASE);
            end else begin
                region = RG_WRAMX;
                offset = OFF_W'(wa - WRAMX_BASE);
            end
        end else if (addr < HOLE_BASE) begin
            region = RG_OAM;
            offset = OFF_W'(addr - OAM_BASE);
        end else if (addr < IO_BASE) begin
            region = RG_HOLE;
            offset = '0;
        end else if (addr < HRAM_BASE) begin
            region = RG_IO;
            offset = OFF_W'(addr - IO_BASE);
        end else if (addr != IE_ADDR) begin
            region = RG_HRAM;
            offset = OFF_W'(addr - HRAM_BASE);
        end else begin
            region = RG_IE;
            offset = '0;
        end
    end
endmodule

// File: rtl/sel_reg.sv
module sel_reg
    import bod_pkg::*;
#(
    parameter int OFF_W  = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  region_e           region,
    input  logic [OFF_W-1:0]  off_d,
    output logic [NREG-1:0]   sel,
    output logic [OFF_W-1:0]  offset,
    output logic              unmapped,
    output logic [DATA_W-1:0] fill_data
);
    logic [NREG-1:0] hit;
    logic            acc, hole, hole_rd;

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (region == region_e'(RID_W'(i)));
    end

    assign acc     = rd_en || wr_en;
    assign hole    = (region == RG_HOLE);
    assign hole_rd = hole && !wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel       <= '0;
            offset    <= '0;
            unmapped  <= 1'b0;
            fill_data <= '0;
        end else if (acc) begin
            sel       <= hole ? '0 : hit;
            offset    <= hole ? '0 : off_d;
            unmapped  <= hole_rd;
            fill_data <= hole_rd ? '1 : '0;
        end else begin
            sel       <= '0;
            offset    <= '0;
            unmapped  <= 1'b0;
            fill_data <= '0;
        end
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import bod_pkg::*;
#(
    parameter int                OFF_W     = 14,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = 16'hFF50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NREG-1:0]   sel,
    output logic [OFF_W-1:0]  offset,
    output logic              unmapped,
    output logic [DATA_W-1:0] fill_data
);
    logic             boot_on;
    region_e          region;
    logic [OFF_W-1:0] off_d;

    bootmode_ctl #(.DATA_W(DATA_W), .EXIT_ADDR(EXIT_ADDR)) u_boot (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .boot_on(boot_on)
    );

    region_map #(.OFF_W(OFF_W)) u_map (
        .addr(addr), .boot_on(boot_on), .region(region), .offset(off_d)
    );

    sel_reg #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .region(region), .off_d(off_d), .sel(sel), .offset(offset),
        .unmapped(unmapped), .fill_data(fill_data)
    );
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk
    import bod_pkg::*;
#(
    parameter int                OFF_W     = 14,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] EXIT_ADDR = 16'hFF50
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              boot_on,
    input logic [NREG-1:0]   sel,
    input logic [OFF_W-1:0]  offset,
    input logic              unmapped,
    input logic [DATA_W-1:0] fill_data
);
    logic in_hole, in_echo, acc;
    assign in_hole = (addr >= 16'hFEA0) && (addr <= 16'hFEFF);
    assign in_echo = (addr >= 16'hE000) && (addr <= 16'hFDFF);
    assign acc     = rd_en || wr_en;

    AST_SEL_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel)); // R12
    AST_SEL_EXACTLY_ONE: assert property (@(posedge clk) disable iff (!rst_n) acc && !in_hole |=> $countones(sel) == 1); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> (sel == '0) && !unmapped && (fill_data == '0) && (offset == '0)); // R11
    AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_en && !wr_en && in_hole |=> unmapped && (fill_data == '1) && (sel == '0) && (offset == '0)); // R9
    AST_HOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en && in_hole |=> !unmapped && (fill_data == '0) && (sel == '0)); // R10
    AST_ECHO_TO_WRAM: assert property (@(posedge clk) disable iff (!rst_n) acc && in_echo |=> (sel[5] || sel[6])); // R7
    AST_BOOT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n) acc && (addr > 16'h00FF) |=> !sel[0]); // R1
    AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (!rst_n) boot_on && wr_en && (addr == EXIT_ADDR) && (wr_data != '0) |=> !boot_on); // R2
    AST_BOOT_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n) boot_on && !(wr_en && (addr == EXIT_ADDR) && (wr_data != '0)) |=> boot_on); // R2
    AST_CART_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !boot_on |=> !boot_on); // R3
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .EXIT_ADDR(EXIT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .boot_on(boot_on), .sel(sel), .offset(offset),
    .unmapped(unmapped), .fill_data(fill_data)
);

// File: tb/boot_overlay_decoder_tb.sv
module boot_overlay_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [10:0] sel;
    logic [13:0] offset;
    logic        unmapped;
    logic [7:0]  fill_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_overlay_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .sel(sel), .offset(offset),
        .unmapped(unmapped), .fill_data(fill_data)
    );

    // Expected decode written from the requirement list.
    task automatic model(input logic [15:0] a, input bit boot,
                         output int idx, output logic [13:0] off, output string req);
        logic [15:0] b;
        if (boot && a <= 16'h00FF) begin idx = 0; off = 14'(a); req = "R1"; end
        else if (a <= 16'h00FF) begin idx = 1; off = 14'(a); req = "R2"; end
        else if (a < 16'h4000) begin idx = 1; off = 14'(a); req = "R4"; end
        else if (a < 16'h8000) begin idx = 2; off = 14'(a - 16'h4000); req = "R4"; end
        else if (a < 16'hA000) begin idx = 3; off = 14'(a - 16'h8000); req = "R5"; end
        else if (a < 16'hC000) begin idx = 4; off = 14'(a - 16'hA000); req = "R5"; end
        else if (a < 16'hFE00) begin
            b = (a >= 16'hE000) ? a - 16'h2000 : a;
            req = (a >= 16'hE000) ? "R7" : "R6";
            if (b < 16'hD000) begin idx = 5; off = 14'(b - 16'hC000); end
            else begin idx = 6; off = 14'(b - 16'hD000); end
        end
        else if (a < 16'hFEA0) begin idx = 7; off = 14'(a - 16'hFE00); req = "R8"; end
        else if (a < 16'hFF00) begin idx = -1; off = '0; req = "R9"; end
        else if (a < 16'hFF80) begin idx = 8; off = 14'(a - 16'hFF00); req = "R8"; end
        else if (a != 16'hFFFF) begin idx = 9; off = 14'(a - 16'hFF80); req = "R8"; end
        else begin idx = 10; off = '0; req = "R8"; end
    endtask

    task automatic check_acc(input string tag, input logic [15:0] a,
                             input bit boot, input bit wr);
        int          idx;
        logic [13:0] e_off;
        string       req;
        logic [10:0] e_sel;
        logic        e_unm;
        logic [7:0]  e_fill;
        model(a, boot, idx, e_off, req);
        if (idx < 0 && wr) req = "R10";
        if (tag != "") req = tag;
        e_sel  = (idx >= 0) ? (11'd1 << idx) : 11'd0;
        e_unm  = (idx < 0) && !wr;
        e_fill = e_unm ? 8'hFF : 8'h00;
        n_checks++;
        if (sel !== e_sel || offset !== e_off || unmapped !== e_unm || fill_data !== e_fill) begin
            n_errors++;
            $display("FAIL %s addr=%h sel=%b exp %b off=%h exp %h unm=%b exp %b fill=%h exp %h",
                     req, a, sel, e_sel, offset, e_off, unmapped, e_unm, fill_data, e_fill);
        end
    endtask

    task automatic check_quiet(input string req);
        n_checks++;
        if (sel !== '0 || offset !== '0 || unmapped !== 1'b0 || fill_data !== '0) begin
            n_errors++;
            $display("FAIL %s idle outputs sel=%b off=%h unm=%b fill=%h exp all zero",
                     req, sel, offset, unmapped, fill_data);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                          input logic [7:0] d, input bit boot, input string tag);
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wr_data = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        check_acc(tag, a, boot, wr);
    endtask

    task automatic sweep(input bit boot);
        for (int i = 0; i <= 65536; i++) begin
            @(negedge clk);
            if (i > 0) check_acc("", 16'(i - 1), boot, 1'b0);
            if (i < 65536) begin addr = 16'(i); rd_en = 1'b1; end
            else rd_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R11");
        access(16'h0000, 1, 0, 8'h00, 1, "R1");
        access(16'h00FF, 1, 0, 8'h00, 1, "R1");
        access(16'h0100, 1, 0, 8'h00, 1, "R4");
    endtask

    task automatic t_no_exit;
        access(16'hFF50, 0, 1, 8'h00, 1, "R2");
        access(16'h0010, 1, 0, 8'h00, 1, "R2");
        access(16'hFF50, 1, 0, 8'h00, 1, "R2");
        access(16'h0020, 1, 0, 8'h00, 1, "R2");
    endtask

    task automatic t_exit;
        access(16'hFF50, 0, 1, 8'h01, 1, "R2");
        access(16'h0000, 1, 0, 8'h00, 0, "R2");
        access(16'h00FF, 0, 1, 8'h00, 0, "R2");
    endtask

    task automatic t_sticky;
        access(16'hFF50, 0, 1, 8'h00, 0, "R3");
        access(16'h0042, 1, 0, 8'h00, 0, "R3");
        access(16'hFF50, 0, 1, 8'hA5, 0, "R3");
        access(16'h0042, 1, 0, 8'h00, 0, "R3");
    endtask

    task automatic t_hole;
        access(16'hFEA0, 1, 0, 8'h00, 0, "R9");
        access(16'hFEFF, 1, 0, 8'h00, 0, "R9");
        access(16'hFEA0, 0, 1, 8'h5A, 0, "R10");
        access(16'hFEC3, 0, 1, 8'hFF, 0, "R10");
        access(16'hFE9F, 0, 1, 8'h11, 0, "R8");
        access(16'hFDFF, 0, 1, 8'h22, 0, "R7");
    endtask

    task automatic t_strobes;
        access(16'hFEB0, 1, 1, 8'h33, 0, "R11");
        access(16'hE123, 1, 1, 8'h44, 0, "R11");
        @(negedge clk);
        check_quiet("R11");
    endtask

    initial begin
        t_reset;
        sweep(1'b1);
        t_no_exit;
        t_exit;
        sweep(1'b0);
        t_sticky;
        t_hole;
        t_strobes;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired before the scenarios completed");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule